// File: doc/BRIEF.md
# Lane-Splittable Add/Logic Unit

This block computes one 64-bit arithmetic or bitwise result from two operands. The same adder can act as a single 64-bit lane, two 32-bit lanes, four 16-bit lanes or eight 8-bit lanes, chosen per transfer. A mux sits between each pair of byte slices. It picks either the carry from the byte below or a fresh lane carry-in, so a carry never crosses a lane edge. Bitwise operations skip the lane logic, because their result does not depend on the lane width.

The combinational core feeds one register stage with valid/ready handshakes on both sides. An input is taken on a rising edge where `in_valid` and `in_ready` are both high. Its result appears on the next cycle with `out_valid` set. The downstream side creates back-pressure by holding `out_ready` low. While it does, the result stays frozen and `in_ready` drops, so no new input is taken. When `out_ready` is high, the stage can hand one result on and take the next input in the same cycle. The lane mode and operation travel with each input.

Top module: `simd_addlogic`

## Requirements
- R1: `lane_mode` sets the lane width: 0 gives one 64-bit lane, 1 gives two 32-bit lanes, 2 gives four 16-bit lanes and 3 gives eight 8-bit lanes. Lane i holds bits [i*w+w-1 : i*w]. No carry passes from one lane into the next.
- R2: With `op_sel` = 0 (add), each lane returns (a + b) mod 2^w.
- R3: With `op_sel` = 1 (subtract), each lane returns (a - b) mod 2^w. This is computed as a + ~b + 1 inside each lane. The lane carry-out is 1 when there is no borrow.
- R4: With `op_sel` = 2, 3 and 4 (AND, OR, XOR), the result is the bitwise function of the full 64 bits in every lane mode, and `lane_cout` is all zero.
- R5: With `op_sel` = 5, 6 or 7, both `result` and `lane_cout` are zero.
- R6: `lane_cout` bit k belongs to byte slot k, bits [8k+7:8k]. For add and subtract, the bit at the top byte slot of each lane carries that lane's carry-out. All other bits are zero.
- R7: An input taken on an edge with `in_valid` and `in_ready` high shows up on `result` and `lane_cout` after that edge, with `out_valid` high. Results leave in the order they were taken.
- R8: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `result`, `lane_cout` and `out_valid` hold their values.
- R9: A synchronous active-high `rst` clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are present |
| in_ready | output | 1 | Stage can take an input this cycle |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| lane_mode | input | 2 | Lane width select (R1 encoding) |
| op_sel | input | 3 | Operation select (R2 to R5 encoding) |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Downstream takes the result this cycle |
| result | output | 64 | Registered lane-wise result |
| lane_cout | output | 8 | Registered carry-out per byte slot |

## Verification
A hand-off of the held result and the capture of a new input can happen in the same cycle. A stall can also come right after an input is taken. The bench provokes both by toggling `out_ready` at random while streaming inputs almost every cycle. A behavioural queue model checks ordering, checks that held data stays stable and compares every retired result lane by lane. Directed carry-boundary operands (all-ones plus one, 0x80 bytes, 0x00 minus 1) are run under every lane mode and every operation. These would show any carry that leaks across a cut or is lost at one.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int SLOT_W = 8;
  localparam int MODE_W = 2;
  localparam int OPS_W  = 3;

  typedef enum logic [OPS_W-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4
  } op_e;
endpackage

// File: rtl/simd_cut_ctl.sv
module simd_cut_ctl #(
  parameter int NSLOT = 8
) (
  input  logic [simd_pkg::MODE_W-1:0] lane_mode,
  output logic [NSLOT-1:0]            cut,
  output logic [NSLOT-1:0]            top
);
  localparam int IW = $clog2(NSLOT) + 1;

  logic [IW-1:0] lane_slots;
  logic [IW-1:0] slot_mask;

  assign lane_slots = IW'(NSLOT) >> lane_mode;
  assign slot_mask  = lane_slots - IW'(1);

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    assign cut[k] = ((IW'(k) & slot_mask) == '0);
    assign top[k] = ((IW'(k + 1) & slot_mask) == '0);
  end

  for (genvar k = 0; k < NSLOT - 1; k++) begin : g_chk
    always_comb begin
      // R6
      top_cut_align_chk: assert (top[k] == cut[k+1]);
    end
  end
endmodule

// File: rtl/simd_byte_slice.sv
module simd_byte_slice #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  assign {cout, sum} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
endmodule

// File: rtl/simd_bitwise.sv
module simd_bitwise #(
  parameter int W = 64
) (
  input  logic [W-1:0]                a,
  input  logic [W-1:0]                b,
  input  logic [simd_pkg::OPS_W-1:0]  op,
  output logic [W-1:0]                y
);
  import simd_pkg::*;
  always_comb begin
    unique case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/simd_addlogic.sv
module simd_addlogic #(
  parameter int NSLOT = 8,
  parameter int SW    = simd_pkg::SLOT_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [NSLOT*SW-1:0]         op_a,
  input  logic [NSLOT*SW-1:0]         op_b,
  input  logic [simd_pkg::MODE_W-1:0] lane_mode,
  input  logic [simd_pkg::OPS_W-1:0]  op_sel,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [NSLOT*SW-1:0]         result,
  output logic [NSLOT-1:0]            lane_cout
);
  import simd_pkg::*;
  localparam int DW = NSLOT * SW;

  logic [NSLOT-1:0] cut, top;
  logic [NSLOT-1:0] slot_cin, slot_cout;
  logic [DW-1:0]    b_eff, arith_sum, logic_y;
  logic             is_sub, is_arith;
  logic [DW-1:0]    res_d;
  logic [NSLOT-1:0] cout_d;

  simd_cut_ctl #(.NSLOT(NSLOT)) u_cut (
    .lane_mode (lane_mode),
    .cut       (cut),
    .top       (top)
  );

  assign is_sub   = (op_sel == OP_SUB);
  assign is_arith = (op_sel == OP_ADD) || is_sub;
  assign b_eff    = is_sub ? ~op_b : op_b;

  for (genvar k = 0; k < NSLOT; k++) begin : g_lane
    if (k == 0) begin : g_first
      assign slot_cin[k] = is_sub;
    end else begin : g_rest
      assign slot_cin[k] = cut[k] ? is_sub : slot_cout[k-1];
    end
    simd_byte_slice #(.W(SW)) u_slice (
      .a    (op_a[k*SW +: SW]),
      .b    (b_eff[k*SW +: SW]),
      .cin  (slot_cin[k]),
      .sum  (arith_sum[k*SW +: SW]),
      .cout (slot_cout[k])
    );
  end

  simd_bitwise #(.W(DW)) u_bitwise (
    .a  (op_a),
    .b  (op_b),
    .op (op_sel),
    .y  (logic_y)
  );

  assign res_d  = is_arith ? arith_sum : logic_y;
  assign cout_d = is_arith ? (slot_cout & top) : '0;

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      result    <= res_d;
      lane_cout <= cout_d;
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(lane_cout)));

  // R7
  accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R4
  bitwise_nocarry_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR))
      |=> (lane_cout == '0));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);
endmodule

// File: tb/tb_simd_addlogic.sv
module tb_simd_addlogic;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] op_a = '0, op_b = '0;
  logic [1:0]  lane_mode = '0;
  logic [2:0]  op_sel = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] result;
  logic [7:0]  lane_cout;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [63:0] exp_r_q[$];
  logic [7:0]  exp_c_q[$];
  logic [2:0]  exp_op_q[$];
  logic        held = 0;
  logic [63:0] held_r;
  logic [7:0]  held_c;

  simd_addlogic dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .lane_mode(lane_mode), .op_sel(op_sel),
    .out_valid(out_valid), .out_ready(out_ready),
    .result(result), .lane_cout(lane_cout)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1 R2 R6";
      3'd1: return "R1 R3 R6";
      3'd2, 3'd3, 3'd4: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic void ref_model(input logic [63:0] a, input logic [63:0] b,
                                    input logic [1:0] m, input logic [2:0] op,
                                    output logic [63:0] r, output logic [7:0] c);
    int w = 64 >> m;
    r = '0; c = '0;
    case (op)
      3'd2: r = a & b;
      3'd3: r = a | b;
      3'd4: r = a ^ b;
      3'd0, 3'd1: begin
        logic [63:0] mask;
        mask = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
        for (int l = 0; l < 64 / w; l++) begin
          logic [64:0] s;
          logic [63:0] av, bv;
          av = (a >> (l * w)) & mask;
          bv = (b >> (l * w)) & mask;
          if (op == 3'd1) bv = ~bv & mask;
          s = {1'b0, av} + {1'b0, bv} + {64'd0, op == 3'd1};
          r = r | ((s[63:0] & mask) << (l * w));
          c[(l * w) / 8 + w / 8 - 1] = s[w];
        end
      end
      default: ;
    endcase
  endfunction

  task automatic step(input logic v, input logic [63:0] a, input logic [63:0] b,
                      input logic [1:0] m, input logic [2:0] op, input logic rdy);
    @(negedge clk);
    in_valid = v; op_a = a; op_b = b; lane_mode = m; op_sel = op; out_ready = rdy;
    #1;
    check(out_valid == (exp_r_q.size() != 0), "R7 out_valid vs queue",
          64'(out_valid), 64'(exp_r_q.size() != 0));
    check(in_ready == (!out_valid || out_ready), "R8 in_ready",
          64'(in_ready), 64'(!out_valid || out_ready));
    if (held && out_valid) begin
      check(result == held_r && lane_cout == held_c, "R8 hold under stall", result, held_r);
    end
    held = out_valid && !out_ready;
    held_r = result; held_c = lane_cout;
    if (out_valid && out_ready && exp_r_q.size() != 0) begin
      logic [63:0] er; logic [7:0] ec; logic [2:0] eo;
      er = exp_r_q.pop_front(); ec = exp_c_q.pop_front(); eo = exp_op_q.pop_front();
      check(result == er, tag_of(eo), result, er);
      check(lane_cout == ec, {tag_of(eo), " cout"}, 64'(lane_cout), 64'(ec));
      held = 0;
    end
    if (v && in_ready) begin
      logic [63:0] er; logic [7:0] ec;
      ref_model(a, b, m, op, er, ec);
      exp_r_q.push_back(er); exp_c_q.push_back(ec); exp_op_q.push_back(op);
    end
  endtask

  initial begin
    logic [63:0] corner_a [6];
    logic [63:0] corner_b [6];
    corner_a[0] = {64{1'b1}};           corner_b[0] = 64'd1;
    corner_a[1] = 64'h8080808080808080; corner_b[1] = 64'h8080808080808080;
    corner_a[2] = 64'd0;                corner_b[2] = 64'd1;
    corner_a[3] = 64'h00FF00FF00FF00FF; corner_b[3] = 64'h0001000100010001;
    corner_a[4] = 64'h7FFFFFFF7FFFFFFF; corner_b[4] = 64'hFFFFFFFF00000001;
    corner_a[5] = 64'h0123456789ABCDEF; corner_b[5] = 64'h0123456789ABCDEF;

    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R9 reset out_valid", 64'(out_valid), 64'd0);
    rst = 1'b0;

    for (int m = 0; m < 4; m++)
      for (int op = 0; op < 8; op++)
        for (int k = 0; k < 6; k++)
          step(1'b1, corner_a[k], corner_b[k], 2'(m), 3'(op), ($urandom % 4) != 0);

    for (int i = 0; i < 2500; i++)
      step(($urandom % 5) != 0, {$urandom, $urandom}, {$urandom, $urandom},
           2'($urandom), 3'($urandom), ($urandom % 3) != 0);

    for (int i = 0; i < 10; i++) step(1'b0, '0, '0, '0, '0, 1'b1);
    check(exp_r_q.size() == 0, "R7 drained", 64'(exp_r_q.size()), 64'd0);

    step(1'b1, 64'd5, 64'd3, 2'd3, 3'd0, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R9 mid-run reset", 64'(out_valid), 64'd0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule